// File: doc/BRIEF.md
# Serial Avionics Word Receiver with Byte Readout

This block takes in a bipolar return-to-zero serial word on two pre-decoded digital lines. A pulse on the "one" line carries a logic 1, a pulse on the "zero" line carries a logic 0, and both lines low means the line is null. Each rising edge on either line shifts one bit into an input register. The first bit received lands in bit 0. A word ends only after the line has stayed null for a set number of edges of a separate, slower gap clock. When a word ends, its bit count is checked and, if enabled, its odd parity. The word then moves in parallel into a 32-bit holding buffer, and the input register is free for the next word at once.

A host reads the holding buffer as four bytes through an active-low read strobe. The bytes come out least-significant first. A ready flag shows that an unread word is waiting, and an error flag describes the last word loaded. The host bus is strobe-based and has no back-pressure. A new word always overwrites the buffer, whether or not the previous word has been read. The tri-state data bus is modelled as a data vector plus an output-enable.

Top module: `arx_word_rx`

## Requirements
- R1: A completed word is stored with the first received bit at bit 0. It is read as four bytes in the order bits 7:0, 15:8, 23:16, 31:24, and the byte index advances on each rising edge of `rd_n`.
- R2: While `rd_n` is low, `bus_oe` is 1 and `bus_data` shows the selected byte. While `rd_n` is high, `bus_oe` is 0.
- R3: `rdy` goes to 1 in the cycle after a word is loaded. It returns to 0 on the rising edge of `rd_n` that ends the read of byte 0.
- R4: With `par_en` = 1, buffer bit 31 is replaced by a parity-error bit. That bit is 1 when the 32 received bits hold an even number of ones. With `par_en` = 0, bit 31 is stored as received.
- R5: `err` is 1 for a loaded word when the received bit count was not exactly 32, or when `par_en` = 1 and the parity check failed. Otherwise it is 0.
- R6: A word ends only after `GAP_TICKS` (default 16) rising edges of `gap_clk` have been seen while both lines are low. A shorter null period inside a word does not split it.
- R7: If `line_one` and `line_zero` are high in the same cycle, the word being received is flagged, and `err` is 1 when that word loads.
- R8: A word that completes before the previous one is read overwrites the buffer, sets `rdy` to 1 again and moves the byte index back to byte 0.
- R9: After `rst_n` is low, `rdy` = 0, `err` = 0, the byte index is 0 and the buffer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| line_one | input | 1 | Digital line that pulses for a 1 bit |
| line_zero | input | 1 | Digital line that pulses for a 0 bit |
| gap_clk | input | 1 | Slow clock that times the inter-word gap |
| par_en | input | 1 | Odd-parity check enable |
| rd_n | input | 1 | Active-low read strobe |
| bus_data | output | 8 | Selected byte of the holding buffer |
| bus_oe | output | 1 | Bus drive enable (high while reading) |
| rdy | output | 1 | Unread word available |
| err | output | 1 | Bit-count, parity or line-clash error of the loaded word |

## Verification
The assertions assume the following about the inputs:
- `line_one`, `line_zero`, `gap_clk` and `rd_n` are synchronous to `clk`.
- Each line pulse lasts at least one clock cycle.
- The gap clock is much slower than `clk`, so a load and a strobe edge rarely coincide.

The stimulus drives every input on the falling clock edge. It holds each bit pulse high for two cycles and then low for two, toggles the gap clock every two cycles, and keeps every pause inside a word well below the gap threshold.

// File: rtl/arx_rx_pkg.sv
package arx_rx_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W) + 1;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [WORD_W-1:0] bits;
    logic [CNT_W-1:0]  count;
    logic              clash;
  } raw_word_t;
endpackage

// File: rtl/arx_bit_capture.sv
module arx_bit_capture
  import arx_rx_pkg::*;
#(
  parameter int GAP_TICKS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_one,
  input  logic      line_zero,
  input  logic      gap_clk,
  output logic      frame_done,
  output raw_word_t frame
);
  localparam int GAP_W = $clog2(GAP_TICKS + 1);

  logic one_q, zero_q, gap_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  nbits;
  logic              clash;
  logic [GAP_W-1:0]  gap_cnt;

  logic one_rise, zero_rise, gap_rise, line_busy, pending, gap_met;
  assign one_rise  = line_one & ~one_q;
  assign zero_rise = line_zero & ~zero_q;
  assign gap_rise  = gap_clk & ~gap_q;
  assign line_busy = line_one | line_zero;
  assign pending   = (nbits != '0) | clash;
  assign gap_met   = (gap_cnt == GAP_W'(GAP_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_q      <= 1'b0;
      zero_q     <= 1'b0;
      gap_q      <= 1'b0;
      shreg      <= '0;
      nbits      <= '0;
      clash      <= 1'b0;
      gap_cnt    <= '0;
      frame_done <= 1'b0;
      frame      <= '0;
    end else begin
      one_q      <= line_one;
      zero_q     <= line_zero;
      gap_q      <= gap_clk;
      frame_done <= 1'b0;
      if (line_busy) gap_cnt <= '0;
      else if (gap_rise && !gap_met) gap_cnt <= gap_cnt + 1'b1;
      if (line_one && line_zero) begin
        clash <= 1'b1;
      end else if (one_rise || zero_rise) begin
        shreg <= {one_rise, shreg[WORD_W-1:1]};
        if (nbits != '1) nbits <= nbits + 1'b1;
      end
      if (!line_busy && gap_met && pending) begin
        frame_done <= 1'b1;
        frame      <= '{bits: shreg, count: nbits, clash: clash};
        shreg      <= '0;
        nbits      <= '0;
        clash      <= 1'b0;
      end
    end
  end

  // R6
  end_on_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !$past(line_one | line_zero));
endmodule

// File: rtl/arx_word_check.sv
module arx_word_check
  import arx_rx_pkg::*;
(
  input  logic              par_en,
  input  raw_word_t         frame,
  output logic [WORD_W-1:0] word_out,
  output logic              word_err
);
  logic par_fail, count_bad;

  always_comb begin
    par_fail  = par_en & ~(^frame.bits);
    count_bad = (frame.count != CNT_W'(WORD_W));
    word_out  = frame.bits;
    if (par_en) word_out[WORD_W-1] = par_fail;
    word_err  = count_bad | frame.clash | par_fail;
  end
endmodule

// File: rtl/arx_byte_readout.sv
module arx_byte_readout
  import arx_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              err_in,
  input  logic              rd_n,
  output logic [BYTE_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              ready,
  output logic              error
);
  localparam int BYTES = WORD_W / BYTE_W;
  localparam int PTR_W = $clog2(BYTES);

  logic              rd_q;
  logic [WORD_W-1:0] hold;
  logic [PTR_W-1:0]  ptr;
  logic              rd_rise;

  assign rd_rise  = rd_n & ~rd_q;
  assign bus_oe   = ~rd_n;
  assign bus_data = hold[ptr*BYTE_W +: BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b1;
      hold  <= '0;
      ptr   <= '0;
      ready <= 1'b0;
      error <= 1'b0;
    end else begin
      rd_q <= rd_n;
      if (load) begin
        hold  <= word_in;
        error <= err_in;
        ready <= 1'b1;
        ptr   <= '0;
      end else if (rd_rise) begin
        ptr <= ptr + 1'b1;
        if (ptr == '0) ready <= 1'b0;
      end
    end
  end

  // R3
  ready_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ready);
  // R3
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !load && ptr == '0) |=> !ready);
  // R8
  ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == '0));
  // R1
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rd_rise) |=> $stable(ptr));
  // R5
  err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && err_in) |=> error);
endmodule

// File: rtl/arx_word_rx.sv
module arx_word_rx
  import arx_rx_pkg::*;
#(
  parameter int GAP_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_one,
  input  logic       line_zero,
  input  logic       gap_clk,
  input  logic       par_en,
  input  logic       rd_n,
  output logic [7:0] bus_data,
  output logic       bus_oe,
  output logic       rdy,
  output logic       err
);
  logic              frame_done;
  raw_word_t         frame;
  logic [WORD_W-1:0] checked_word;
  logic              checked_err;

  arx_bit_capture #(.GAP_TICKS(GAP_TICKS)) u_capture (
    .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
    .gap_clk(gap_clk), .frame_done(frame_done), .frame(frame)
  );

  arx_word_check u_check (
    .par_en(par_en), .frame(frame), .word_out(checked_word), .word_err(checked_err)
  );

  arx_byte_readout u_readout (
    .clk(clk), .rst_n(rst_n), .load(frame_done), .word_in(checked_word),
    .err_in(checked_err), .rd_n(rd_n), .bus_data(bus_data), .bus_oe(bus_oe),
    .ready(rdy), .error(err)
  );
endmodule

// File: tb/tb_arx_word_rx.sv
module tb_arx_word_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_one = 1'b0, line_zero = 1'b0, gap_clk = 1'b0, par_en = 1'b0, rd_n = 1'b1;
  logic [7:0] bus_data;
  logic bus_oe, rdy, err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  arx_word_rx dut (
    .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
    .gap_clk(gap_clk), .par_en(par_en), .rd_n(rd_n), .bus_data(bus_data),
    .bus_oe(bus_oe), .rdy(rdy), .err(err)
  );

  initial forever begin
    repeat (2) @(negedge clk);
    gap_clk = ~gap_clk;
  end

  // {par_en, nbits, word}
  localparam logic [38:0] VEC [7] = '{
    {1'b0, 6'd32, 32'h12345678},
    {1'b1, 6'd32, 32'h12345678},
    {1'b1, 6'd32, 32'h00000003},
    {1'b1, 6'd32, 32'hFFFFFFFE},
    {1'b0, 6'd32, 32'hC0FFEE01},
    {1'b0, 6'd31, 32'hA5A5A5A5},
    {1'b0, 6'd33, 32'h0F0F0F0F}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_bit(logic b);
    @(negedge clk);
    if (b) line_one = 1'b1; else line_zero = 1'b1;
    repeat (2) @(negedge clk);
    line_one = 1'b0; line_zero = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] w, int first, int last);
    for (int i = first; i < last; i++) pulse_bit(i < 32 ? w[i] : 1'b0);
  endtask

  task automatic wait_gap();
    repeat (120) @(negedge clk);
  endtask

  task automatic read_byte(output logic [7:0] b, output logic oe);
    @(negedge clk);
    rd_n = 1'b0;
    #1;
    b = bus_data; oe = bus_oe;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic oe;
    logic [31:0] w, expw;
    logic expe;
    int n;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 rdy", rdy, 0);
    check("R9 err", err, 0);
    check("R2 oe idle", bus_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_byte(b, oe);
    check("R9 buffer cleared", b, 0);

    for (int v = 0; v < 7; v++) begin
      w = VEC[v][31:0]; n = int'(VEC[v][37:32]); par_en = VEC[v][38];
      expw = w;
      if (par_en) expw[31] = ~^w;
      expe = (n != 32) || (par_en && !(^w));
      send_bits(w, 0, n);
      wait_gap();
      check("R3 rdy after load", rdy, 1);
      check("R5 err", err, expe);
      for (int k = 0; k < 4; k++) begin
        read_byte(b, oe);
        check("R2 oe during read", oe, 1);
        if (n == 32) check("R1/R4 byte", b, expw[k*8 +: 8]);
        if (k == 0) check("R3 rdy cleared by first read", rdy, 0);
      end
      check("R2 oe released", bus_oe, 0);
    end

    // R6: short pause mid-word does not split it
    par_en = 1'b0;
    w = 32'h5AC3_9E17;
    send_bits(w, 0, 16);
    repeat (40) @(negedge clk);
    check("R6 no early frame", rdy, 0);
    send_bits(w, 16, 32);
    wait_gap();
    check("R6 rdy", rdy, 1);
    check("R6 err", err, 0);
    read_byte(b, oe);
    check("R6 byte0", b, w[7:0]);

    // R7: both lines active
    send_bits(w, 0, 10);
    @(negedge clk);
    line_one = 1'b1; line_zero = 1'b1;
    repeat (2) @(negedge clk);
    line_one = 1'b0; line_zero = 1'b0;
    send_bits(w, 10, 32);
    wait_gap();
    check("R7 rdy", rdy, 1);
    check("R7 err on clash", err, 1);

    // R8: overwrite mid-read, then overwrite unread word
    send_bits(32'h1122_3344, 0, 32);
    wait_gap();
    read_byte(b, oe);
    check("R8 first word byte0", b, 8'h44);
    check("R8 err clean", err, 0);
    send_bits(32'hDEAD_BEEF, 0, 32);
    wait_gap();
    check("R8 rdy reasserted", rdy, 1);
    send_bits(32'h0BAD_F00D, 0, 32);
    wait_gap();
    read_byte(b, oe);
    check("R8 restart at byte0", b, 8'h0D);
    read_byte(b, oe);
    check("R8 byte1", b, 8'hF0);

    summary();
    $finish;
  end
endmodule